// File: doc/BRIEF.md
# Drift Hit Track Segment Finder

This block turns discriminated drift-cell hits into track-segment triggers. The hit lines change with no relation to the system clock. Each line is brought into the clock domain through a short flip-flop chain, and its rising edge is detected there. A counter then holds that cell active for a fixed window of about one maximum drift time. Because of this window, hits from one particle still overlap even though they reach the electronics at different moments.

The cells form four stacked layers of equal width. A pattern is a chain of four neighbouring cells, one in each layer, built around a pivot cell in the second layer. Four base shapes are defined for each pivot, and their left/right mirror images give four more. When all four cells of a pattern are active in the same cycle, that pattern's output bit goes high. A global trigger goes high whenever any pattern output is high.

Top module: `drift_segment_finder`

## Requirements
- R1: While `rst_n` is low, every bit of `track_o` and `trigger_o` is low, and no hit that arrived before reset release is remembered.
- R2: If a hit line rises and is first sampled high on clock edge n, and the other three cells of a pattern are already active, that pattern's output is high right after edge n+3.
- R3: One hit pulse keeps its cell active for exactly STRETCH_CYCLES cycles (default 24, i.e. 480 ns at 50 MHz). A pattern formed by one simultaneous pulse on its four cells is therefore high for exactly STRETCH_CYCLES consecutive cycles.
- R4: A new rising edge on a cell that is already active reloads the window to its full length.
- R5: A hit line that stays high produces only one window. The cell becomes inactive STRETCH_CYCLES cycles after the window starts, even if the line is still high.
- R6: Cell index = layer*COLS + column, with layer 0..3 and column 0..COLS-1. Track index = pivot*8 + mirror*4 + shape. The pivot column is pivot+1, for pivot 0..COLS-3. Column offsets for layers 0..3 are: shape0 (0,0,+1,+1), shape1 (-1,0,+1,+1), shape2 (0,0,0,+1), shape3 (-1,0,0,+1). The mirror bit negates all four offsets.
- R7: A pattern with only three of its four cells active produces no output.
- R8: All patterns whose cells are active at the same time are reported together.
- R9: `trigger_o` is high in exactly the cycles in which at least one bit of `track_o` is high.
- R10: Hits on the four cells of a pattern that arrive at different times still match, provided their windows overlap. The output is high only during the overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 4*COLS | Discriminated cell hits, asynchronous to `clk` |
| track_o | output | 8*(COLS-2) | One registered bit per matched pattern |
| trigger_o | output | 1 | Registered OR of all pattern matches |

## Verification
The bench builds the block with COLS=7, STRETCH_CYCLES=24 and SYNC_STAGES=2. This gives 28 inputs and 40 patterns. At this width the two end pivots, where a mirrored shape reaches column 0 or column 6, are part of the set, and every one of the 40 patterns is fired alone and compared at each cycle. The full 24-cycle window makes it possible to test retriggering, a line held high past the window, and arrivals staggered by six cycles against the exact length of the overlap.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   // Fixed geometry of one pattern: four layers, four base shapes, mirrored.
   localparam int unsigned LAYERS    = 4;
   localparam int unsigned SHAPES    = 4;
   localparam int unsigned PER_PIVOT = 2 * SHAPES;

   // Column offset of a shape in a layer, relative to the pivot (layer 1).
   function automatic int shape_offset(input int shape, input int layer);
      case (shape)
         0: return (layer >= 2) ? 1 : 0;
         1: return (layer == 0) ? -1 : ((layer >= 2) ? 1 : 0);
         2: return (layer == 3) ? 1 : 0;
         3: return (layer == 0) ? -1 : ((layer == 3) ? 1 : 0);
         default: return 0;
      endcase
   endfunction

   // Flat cell index used by a track in a given layer.
   function automatic int cell_of(input int track, input int layer, input int cols);
      int pivot;
      int rest;
      int off;
      pivot = track / PER_PIVOT;
      rest  = track % PER_PIVOT;
      off   = shape_offset(rest % SHAPES, layer);
      if ((rest / SHAPES) != 0) off = -off;
      return layer * cols + pivot + 1 + off;
   endfunction
endpackage

// File: rtl/tsf_hit_sync.sv
module tsf_hit_sync #(
   parameter int unsigned WIDTH  = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tsf_hit_sync: STAGES must be at least 2");
   end

   // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous value
   logic [STAGES:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= async_i;
         for (int s = 1; s <= STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tsf_stretch.sv
module tsf_stretch #(
   parameter int unsigned WIDTH = 28,
   parameter int unsigned LEN   = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rise_i,
   output logic [WIDTH-1:0] active_o
);
   localparam int unsigned CW = $clog2(LEN + 1);

   if (LEN < 1) begin : g_bad_len
      $error("tsf_stretch: LEN must be at least 1");
   end

   for (genvar c = 0; c < WIDTH; c++) begin : g_cell
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt <= '0;
         else if (rise_i[c])      cnt <= CW'(LEN);
         else if (cnt != '0)      cnt <= cnt - 1'b1;
      end
      assign active_o[c] = (cnt != '0);
   end
endmodule

// File: rtl/tsf_match.sv
module tsf_match #(
   parameter int unsigned COLS = 7
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [tsf_pkg::LAYERS*COLS-1:0]         active_i,
   output logic [tsf_pkg::PER_PIVOT*(COLS-2)-1:0]  track_o,
   output logic                                    trigger_o
);
   localparam int unsigned N_TRACKS = tsf_pkg::PER_PIVOT * (COLS - 2);

   logic [N_TRACKS-1:0] hit_all;

   for (genvar t = 0; t < N_TRACKS; t++) begin : g_track
      localparam int C0 = tsf_pkg::cell_of(t, 0, COLS);
      localparam int C1 = tsf_pkg::cell_of(t, 1, COLS);
      localparam int C2 = tsf_pkg::cell_of(t, 2, COLS);
      localparam int C3 = tsf_pkg::cell_of(t, 3, COLS);
      assign hit_all[t] = active_i[C0] & active_i[C1] & active_i[C2] & active_i[C3];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         track_o   <= '0;
         trigger_o <= 1'b0;
      end else begin
         track_o   <= hit_all;
         trigger_o <= |hit_all;
      end
   end
endmodule

// File: rtl/drift_segment_finder.sv
module drift_segment_finder #(
   parameter int unsigned COLS           = 7,
   parameter int unsigned STRETCH_CYCLES = 24,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [tsf_pkg::LAYERS*COLS-1:0]         hit_i,
   output logic [tsf_pkg::PER_PIVOT*(COLS-2)-1:0]  track_o,
   output logic                                    trigger_o
);
   localparam int unsigned N_HITS = tsf_pkg::LAYERS * COLS;

   if (COLS < 3) begin : g_bad_cols
      $error("drift_segment_finder: COLS must be at least 3");
   end

   logic [N_HITS-1:0] hit_rise;
   logic [N_HITS-1:0] stretched;

   tsf_hit_sync #(.WIDTH(N_HITS), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_i(hit_i), .rise_o(hit_rise));

   tsf_stretch #(.WIDTH(N_HITS), .LEN(STRETCH_CYCLES)) i_stretch (
      .clk(clk), .rst_n(rst_n), .rise_i(hit_rise), .active_o(stretched));

   tsf_match #(.COLS(COLS)) i_match (
      .clk(clk), .rst_n(rst_n), .active_i(stretched),
      .track_o(track_o), .trigger_o(trigger_o));
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
   parameter int unsigned COLS = 7
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic [tsf_pkg::LAYERS*COLS-1:0]         hit_rise,
   input logic [tsf_pkg::LAYERS*COLS-1:0]         stretched,
   input logic [tsf_pkg::PER_PIVOT*(COLS-2)-1:0]  track_o,
   input logic                                    trigger_o
);
   localparam int unsigned N_HITS   = tsf_pkg::LAYERS * COLS;
   localparam int unsigned N_TRACKS = tsf_pkg::PER_PIVOT * (COLS - 2);

   // R1: outputs are cleared while reset is held
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (track_o == '0 && !trigger_o));

   // R9: trigger follows the presence of any track
   p_trigger_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trigger_o == (track_o != '0));

   for (genvar c = 0; c < N_HITS; c++) begin : g_cell
      // R2: a window only opens after a detected edge
      p_window_from_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stretched[c]) |-> $past(hit_rise[c]));
      // R4: an edge always leaves the cell active next cycle
      p_edge_reloads_r4: assert property (@(posedge clk) disable iff (!rst_n)
         hit_rise[c] |=> stretched[c]);
   end

   for (genvar t = 0; t < N_TRACKS; t++) begin : g_track
      localparam int C0 = tsf_pkg::cell_of(t, 0, COLS);
      localparam int C1 = tsf_pkg::cell_of(t, 1, COLS);
      localparam int C2 = tsf_pkg::cell_of(t, 2, COLS);
      localparam int C3 = tsf_pkg::cell_of(t, 3, COLS);
      // R6: a track bit needs its four cells active one cycle before
      p_track_cells_r6: assert property (@(posedge clk) disable iff (!rst_n)
         track_o[t] |-> $past(stretched[C0] && stretched[C1] && stretched[C2] && stretched[C3]));
   end
endmodule

bind drift_segment_finder tsf_checker #(.COLS(COLS)) i_tsf_checker (
   .clk(clk), .rst_n(rst_n), .hit_rise(hit_rise), .stretched(stretched),
   .track_o(track_o), .trigger_o(trigger_o));

// File: tb/test_drift_segment_finder.sv
`timescale 1ns/1ps
module test_drift_segment_finder;
   localparam int COLS = 7;
   localparam int L    = 24;
   localparam int NH   = 4 * COLS;
   localparam int NT   = 8 * (COLS - 2);
   localparam int LAT  = 4;
   localparam int OFF [16] = '{0, 0, 1, 1,  -1, 0, 1, 1,  0, 0, 0, 1,  -1, 0, 0, 1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NH-1:0] hit_i = '0;
   logic [NT-1:0] track_o;
   logic          trigger_o;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      int            at;
      logic [NT-1:0] trk;
      logic          trig;
      string         tag;
   } item_t;
   item_t sb[$];
   item_t mon_it;

   int            last_rise [NH];
   logic [NH-1:0] prev_drv = '0;

   drift_segment_finder #(.COLS(COLS), .STRETCH_CYCLES(L), .SYNC_STAGES(2)) i_drift_segment_finder (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .track_o(track_o), .trigger_o(trigger_o));

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int b_cell(int trk, int lay);
      int piv = trk / 8;
      int r   = trk % 8;
      int o   = OFF[(r % 4) * 4 + lay];
      if (r / 4 != 0) o = -o;
      return lay * COLS + piv + 1 + o;
   endfunction

   function automatic logic [NH-1:0] track_mask(int trk);
      logic [NH-1:0] m = '0;
      for (int l = 0; l < 4; l++) m[b_cell(trk, l)] = 1'b1;
      return m;
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // driver: applies one cycle of hits and queues the output due LAT cycles later
   task automatic step(logic [NH-1:0] h, string tag);
      item_t it;
      logic [NH-1:0] act;
      int d;
      @(negedge clk);
      hit_i = h;
      for (int c = 0; c < NH; c++)
         if (h[c] && !prev_drv[c]) last_rise[c] = cyc;
      prev_drv = h;
      for (int c = 0; c < NH; c++) begin
         d = cyc + LAT - last_rise[c];
         act[c] = (d >= 4) && (d <= 3 + L);
      end
      it.at  = cyc + LAT;
      it.trk = '0;
      for (int t = 0; t < NT; t++) it.trk[t] = ((act & track_mask(t)) == track_mask(t));
      it.trig = (it.trk != '0);
      it.tag  = tag;
      sb.push_back(it);
   endtask

   task automatic pulse(logic [NH-1:0] m, string tag, int width, int idle);
      for (int i = 0; i < width; i++) step(m, tag);
      for (int i = 0; i < idle; i++) step('0, tag);
   endtask

   // monitor: compares every queued expectation in its cycle
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].at == cyc) begin
         mon_it = sb.pop_front();
         check(track_o == mon_it.trk, mon_it.tag, "track_o", 64'(track_o), 64'(mon_it.trk));
         check(trigger_o == mon_it.trig, "R9", "trigger_o", 64'(trigger_o), 64'(mon_it.trig));
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [NH-1:0] m;
      for (int c = 0; c < NH; c++) last_rise[c] = -1000;
      repeat (5) @(negedge clk);
      // R1: outputs quiet in reset
      check(track_o == '0 && !trigger_o, "R1", "reset outputs", 64'(track_o), 64'd0);
      rst_n = 1'b1;
      pulse('0, "R1", 1, 4);

      // R2 / R3: single simultaneous pulse on track 0, then on track 13
      pulse(track_mask(0), "R2", 2, 34);
      pulse(track_mask(13), "R3", 1, 34);

      // R7: three of four cells of track 5
      m = track_mask(5);
      m[b_cell(5, 2)] = 1'b0;
      pulse(m, "R7", 2, 34);

      // R10: staggered arrivals on track 10
      pulse(1 << b_cell(10, 0), "R10", 2, 4);
      pulse(1 << b_cell(10, 1), "R10", 2, 4);
      pulse(1 << b_cell(10, 2), "R10", 2, 4);
      pulse(1 << b_cell(10, 3), "R10", 2, 34);

      // R4: retrigger during the window on track 20
      pulse(track_mask(20), "R4", 2, 18);
      pulse(track_mask(20), "R4", 2, 34);

      // R5: lines held high for 60 cycles on track 27
      pulse(track_mask(27), "R5", 60, 34);

      // R8: every cell at once matches every pattern
      pulse('1, "R8", 2, 34);
      // R8: one pattern and its mirror together
      pulse(track_mask(32) | track_mask(36), "R8", 2, 34);

      // R6: each pattern alone, including the edge pivots
      for (int t = 0; t < NT; t++) pulse(track_mask(t), "R6", 2, 30);

      repeat (LAT + 4) @(negedge clk);
      check(sb.size() == 0, "R6", "scoreboard drained", 64'(sb.size()), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule